// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Controller

This block guards an I2C bus against the lockup that follows a master reset in the middle of a transfer. In that lockup a slave is still holding SDA low, either for an acknowledge or for a data bit of 0. It waits for a falling SCL edge that never comes, while SCL floats high. The controller watches both lines through a two-flop synchronizer. It can then release the slave by clocking SCL with open-drain pulses until SDA reads high, up to a fixed cap of nine pulses. After the pulses it places a STOP condition on the bus and reports the outcome.

Recovery can start in three ways. Leaving reset, the block checks the bus once and recovers on its own if SDA is low. In idle, a one-cycle request starts a recovery. With monitoring enabled, recovery also starts once the deadlock pattern has persisted for a programmable number of clocks. Nothing can interrupt a sequence once it has begun. Both outputs are open-drain enables: a 1 pulls the line low, and a 0 releases it, so the block never drives a line high.

Top module: `i2c_bus_unjam`

## Requirements
- R1: `scl_oe` and `sda_oe` are enables that pull a line low when 1 and release it when 0. During and after reset, and whenever no recovery is running, both are 0, and `busy`, `done` and `fail` are 0 until the first recovery.
- R2: After reset the block waits for its synchronizer to settle and then samples SDA. If SDA is low, recovery starts without any request. If SDA is high, the block stays idle.
- R3: Each SCL pulse holds SCL low for exactly `low_cycles` clocks and then releases it for exactly `high_cycles` clocks.
- R4: At the end of each high half-period SDA is sampled. If it reads high, pulsing stops and the STOP sequence follows, so a slave that lets go after k falling edges sees exactly k pulses.
- R5: No more than 9 pulses are issued in one recovery, whatever SDA does.
- R6: The STOP sequence runs in this order. SCL is pulled low, then SDA is pulled low while SCL is low, then SCL is released, and then SDA is released while SCL is high. SDA is never pulled low while SCL is released.
- R7: `busy` is 1 for the whole sequence. At the end, `done` is set if SDA reads high after the STOP, and `fail` is set otherwise, never both. The flags hold until the next recovery starts, which clears them.
- R8: With `monitor_en` at 1 in idle, recovery starts once SCL high with SDA low has lasted `stuck_limit` consecutive clocks. A shorter hold has no effect, and with `monitor_en` at 0 no hold ever starts a recovery.
- R9: A 1 on `kick` in idle starts a recovery, even on a free bus, which then gets one pulse. `kick` is ignored while a recovery is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| kick | input | 1 | Request a recovery (idle only) |
| monitor_en | input | 1 | Enable the stuck-SDA timeout watch |
| low_cycles | input | HALF_W | SCL low half-period in clocks |
| high_cycles | input | HALF_W | SCL high half-period in clocks |
| stuck_limit | input | LIMIT_W | Deadlock duration that triggers recovery |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | Last recovery freed the bus |
| fail | output | 1 | Last recovery left SDA low |

## Verification
The bench attaches a slave model that holds SDA until it has seen a chosen number of SCL falling edges. It counts every falling edge, so a design that sampled SDA at the wrong point, or kept pulsing after release, gives the wrong count. A slave that never lets go shows whether the nine-pulse cap holds and whether `fail` rises instead of `done`. A second request in the middle of that run would restart the count and push it past ten edges. Holding SDA just short of the timeout, and again with monitoring off, catches a watch that does not clear or that ignores the enable. The bench also checks for a rising SDA while SCL is high and measures the length of each half-period, which exposes a missing STOP or a half-period off by one.

// File: rtl/unjam_pkg.sv
package unjam_pkg;
  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_IDLE,
    ST_PULSE_LO,
    ST_PULSE_HI,
    ST_STOP_LO,
    ST_STOP_HI,
    ST_STOP_END
  } unjam_state_e;

  localparam int unsigned STD_HALF_CLKS = 250;
endpackage

// File: rtl/unjam_sync.sv
module unjam_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '1;
          else     chain[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/unjam_phase_timer.sv
module unjam_phase_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] len,
  output logic         last
);
  logic [W-1:0] cnt;
  logic [W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  // a length of 0 behaves like 1
  assign last    = (cnt_inc >= {1'b0, len});

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (!last)     cnt <= cnt + 1'b1;
  end

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0)); // R3
endmodule

// File: rtl/unjam_stuck_watch.sv
module unjam_stuck_watch #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         scl_s,
  input  logic         sda_s,
  input  logic [W-1:0] limit,
  output logic         stuck
);
  logic [W-1:0] held;
  logic         pattern;

  assign pattern = scl_s && !sda_s;
  assign stuck   = enable && pattern && (held >= limit);

  always_ff @(posedge clk) begin
    if (rst || !enable || !pattern) held <= '0;
    else if (held < limit)          held <= held + 1'b1;
  end

  AST_WATCH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !(scl_s && !sda_s) |=> (held == '0)); // R8
endmodule

// File: rtl/i2c_bus_unjam.sv
module i2c_bus_unjam
  import unjam_pkg::*;
#(
  parameter int unsigned HALF_W      = 16,
  parameter int unsigned LIMIT_W     = 24,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MAX_PULSES  = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic               kick,
  input  logic               monitor_en,
  input  logic [HALF_W-1:0]  low_cycles,
  input  logic [HALF_W-1:0]  high_cycles,
  input  logic [LIMIT_W-1:0] stuck_limit,
  output logic               scl_oe,
  output logic               sda_oe,
  output logic               busy,
  output logic               done,
  output logic               fail
);
  localparam int unsigned PC_W       = $clog2(MAX_PULSES + 1);
  localparam int unsigned SETTLE_LEN = SYNC_STAGES + 1;

  unjam_state_e      state, nxt;
  logic [1:0]        line_s;
  logic              scl_s, sda_s;
  logic              phase_last, stuck, start;
  logic [HALF_W-1:0] phase_len;
  logic [PC_W-1:0]   pulse_cnt;

  unjam_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  always_comb begin
    if (state == ST_SETTLE)
      phase_len = HALF_W'(SETTLE_LEN);
    else if (state == ST_PULSE_LO || state == ST_STOP_LO)
      phase_len = low_cycles;
    else
      phase_len = high_cycles;
  end

  unjam_phase_timer #(.W(HALF_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (state != nxt),
    .len     (phase_len),
    .last    (phase_last)
  );

  unjam_stuck_watch #(.W(LIMIT_W)) u_watch (
    .clk    (clk),
    .rst    (rst),
    .enable (monitor_en && state == ST_IDLE),
    .scl_s  (scl_s),
    .sda_s  (sda_s),
    .limit  (stuck_limit),
    .stuck  (stuck)
  );

  always_comb begin
    nxt   = state;
    start = 1'b0;
    case (state)
      ST_SETTLE:   if (phase_last) begin
                     start = !sda_s;
                     nxt   = sda_s ? ST_IDLE : ST_PULSE_LO;
                   end
      ST_IDLE:     if (kick || stuck) begin
                     start = 1'b1;
                     nxt   = ST_PULSE_LO;
                   end
      ST_PULSE_LO: if (phase_last) nxt = ST_PULSE_HI;
      ST_PULSE_HI: if (phase_last)
                     nxt = (sda_s || pulse_cnt >= PC_W'(MAX_PULSES)) ? ST_STOP_LO : ST_PULSE_LO;
      ST_STOP_LO:  if (phase_last) nxt = ST_STOP_HI;
      ST_STOP_HI:  if (phase_last) nxt = ST_STOP_END;
      ST_STOP_END: if (phase_last) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_SETTLE;
      pulse_cnt <= '0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      state  <= nxt;
      busy   <= !(nxt inside {ST_SETTLE, ST_IDLE});
      scl_oe <= (nxt == ST_PULSE_LO) || (nxt == ST_STOP_LO);
      // SDA is pulled only from the second STOP_LO cycle, after SCL is already low
      sda_oe <= (nxt == ST_STOP_LO && state == ST_STOP_LO) || (nxt == ST_STOP_HI);
      if (start) begin
        pulse_cnt <= PC_W'(1);
        done      <= 1'b0;
        fail      <= 1'b0;
      end else if (state == ST_PULSE_HI && nxt == ST_PULSE_LO) begin
        pulse_cnt <= pulse_cnt + 1'b1;
      end
      if (state == ST_STOP_END && phase_last) begin
        done <= sda_s;
        fail <= !sda_s;
      end
    end
  end

  AST_RELEASED_IN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (!scl_oe && !sda_oe)); // R1
  AST_EARLY_STOP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PULSE_HI && phase_last && sda_s) |=> (state == ST_STOP_LO)); // R4
  AST_PULSE_CAP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PULSE_LO) |-> (pulse_cnt >= 1 && pulse_cnt <= PC_W'(MAX_PULSES))); // R5
  AST_SDA_PULL_UNDER_LOW_SCL: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> scl_oe); // R6
  AST_SDA_FREE_UNDER_HIGH_SCL: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> !scl_oe); // R6
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    !(done && fail)); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && state != ST_STOP_END) |=> busy); // R9
endmodule

// File: tb/i2c_bus_unjam_bench.sv
module i2c_bus_unjam_bench;
  localparam int LOW   = 10;
  localparam int HIGH  = 10;
  localparam int LIMIT = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kick = 1'b0;
  logic monitor_en = 1'b0;
  logic scl_oe, sda_oe, busy, done, fail;

  // slave model controls (owned by the test tasks)
  logic hold_en = 1'b0;
  int   need = 0;
  logic clr = 1'b0;

  // observers (owned by the clocked monitor)
  int   falls, low_run, high_run, last_low, last_high;
  logic stop_seen, scl_prev, sda_prev;

  int errors = 0;
  int checks = 0;

  wire slave_hold = hold_en && (falls < need);
  wire scl_line   = ~scl_oe;
  wire sda_line   = ~(sda_oe | slave_hold);

  always #10 clk = ~clk;

  i2c_bus_unjam u_i2c_bus_unjam (
    .clk         (clk),
    .rst         (rst),
    .scl_in      (scl_line),
    .sda_in      (sda_line),
    .kick        (kick),
    .monitor_en  (monitor_en),
    .low_cycles  (16'(LOW)),
    .high_cycles (16'(HIGH)),
    .stuck_limit (24'(LIMIT)),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe),
    .busy        (busy),
    .done        (done),
    .fail        (fail)
  );

  always @(posedge clk) begin
    if (clr) begin
      falls <= 0; low_run <= 0; high_run <= 0;
      last_low <= 0; last_high <= 0; stop_seen <= 1'b0;
    end else begin
      if (scl_prev && !scl_line) begin
        falls <= falls + 1;
        last_high <= high_run;
      end
      if (!scl_prev && scl_line) last_low <= low_run;
      low_run  <= scl_line ? 0 : low_run + 1;
      high_run <= scl_line ? high_run + 1 : 0;
      if (!sda_prev && sda_line && scl_prev && scl_line) stop_seen <= 1'b1;
    end
    scl_prev <= scl_line;
    sda_prev <= sda_line;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_obs();
    clr = 1'b1; cycles(1); clr = 1'b0;
  endtask

  task automatic pulse_kick();
    kick = 1'b1; cycles(1); kick = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) cycles(1);
    cycles(2);
  endtask

  task automatic t_reset_free();
    hold_en = 1'b0;
    rst = 1'b1; clear_obs(); cycles(4); rst = 1'b0;
    cycles(20);
    chk("R1", "scl_oe after reset", int'(scl_oe), 0);
    chk("R1", "sda_oe after reset", int'(sda_oe), 0);
    chk("R2", "busy on free bus", int'(busy), 0);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "fail after reset", int'(fail), 0);
  endtask

  task automatic t_reset_stuck();
    hold_en = 1'b1; need = 3;
    rst = 1'b1; clear_obs(); cycles(4); rst = 1'b0;
    cycles(8);
    chk("R2", "auto recovery busy", int'(busy), 1);
    wait_idle();
    chk("R4", "falls for 3-edge slave", falls, 4);
    chk("R3", "low half-period", last_low, LOW);
    chk("R3", "high half-period", last_high, HIGH);
    chk("R6", "stop seen", int'(stop_seen), 1);
    chk("R7", "done", int'(done), 1);
    chk("R7", "fail", int'(fail), 0);
    chk("R1", "lines released", int'(scl_oe | sda_oe), 0);
    hold_en = 1'b0;
  endtask

  task automatic t_kick_free();
    hold_en = 1'b0; clear_obs();
    pulse_kick(); cycles(2);
    chk("R9", "kick starts recovery", int'(busy), 1);
    wait_idle();
    chk("R9", "falls on free bus", falls, 2);
    chk("R7", "done on free bus", int'(done), 1);
  endtask

  task automatic t_stubborn();
    hold_en = 1'b1; need = 1000; clear_obs();
    pulse_kick(); cycles(50);
    pulse_kick(); cycles(30);
    pulse_kick();
    wait_idle();
    chk("R5", "falls with stubborn slave (R9 second kick ignored)", falls, 10);
    chk("R7", "fail set", int'(fail), 1);
    chk("R7", "done clear", int'(done), 0);
    hold_en = 1'b0; cycles(20);
    chk("R7", "fail holds", int'(fail), 1);
  endtask

  task automatic t_monitor();
    int early;
    monitor_en = 1'b1;
    hold_en = 1'b1; need = 2; clear_obs();
    early = 0;
    for (int i = 0; i < 60; i++) begin cycles(1); if (busy) early++; end
    hold_en = 1'b0;
    cycles(10);
    chk("R8", "short hold triggers nothing", early + int'(busy), 0);
    clear_obs(); hold_en = 1'b1;
    early = 0;
    for (int i = 0; i < LIMIT - 5; i++) begin cycles(1); if (busy) early++; end
    chk("R8", "no start before limit", early, 0);
    cycles(20);
    chk("R8", "start after limit", int'(busy), 1);
    chk("R7", "flags cleared at start", int'(fail), 0);
    wait_idle();
    chk("R8", "falls after timeout recovery", falls, 3);
    chk("R7", "done after timeout recovery", int'(done), 1);
    hold_en = 1'b0;
  endtask

  task automatic t_monitor_off();
    int seen;
    monitor_en = 1'b0;
    hold_en = 1'b1; need = 2; clear_obs();
    seen = 0;
    for (int i = 0; i < 3 * LIMIT; i++) begin cycles(1); if (busy) seen++; end
    chk("R8", "monitor off never starts", seen, 0);
    chk("R8", "no SCL activity", falls, 0);
    hold_en = 1'b0; cycles(5);
  endtask

  initial begin
    cycles(2);
    t_reset_free();
    t_reset_stuck();
    t_kick_free();
    t_stubborn();
    t_monitor();
    t_monitor_off();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule